// File: doc/BRIEF.md
# Store Path with Delayed Data-Array Write

This block is the store side of a small direct-mapped cache whose data array has a single write port. A store that hits in the tag array does not write the array in the cycle of its tag check. Its word address and data are parked in a one-entry holding register. The array write happens later, in the same cycle as the tag check of the next store hit. A store therefore takes one cycle of the array instead of two, and back-to-back stores run at one per cycle.

A load reads the tag and data arrays in its own cycle. If the pending store targets the same word, the load takes the parked data instead of the stale array contents. A flush input drains the pending write without a new store. The block signals a miss but does not refill. The next level installs a line through a fill port, which writes the tag and the data together.

The request port takes one load or store per cycle. Each request gets a registered response in the following cycle, carrying a hit flag and, for loads, the read data. Addresses are 32-bit byte addresses. There are 64 lines of one 32-bit word. The low two address bits are ignored, the next six bits select the line, and the upper 24 bits are the tag.

Top module: `dwr_store_pipe`

## Requirements
- R1: After reset no line is valid and no write is pending, so every load or store misses until a fill installs a line; rsp_valid is 0 after reset.
- R2: A request accepted in cycle n produces rsp_valid=1 in cycle n+1, with rsp_store equal to the request's store flag. A cycle without a request produces rsp_valid=0 in the next cycle.
- R3: A store whose tag matches a valid line returns rsp_hit=1 and rsp_rdata=0. Its data then becomes the value returned by loads of that word address.
- R4: A store that misses returns rsp_hit=0. It leaves both the pending write and the array unchanged, so a later load of the pending word still returns the pending data.
- R5: A load that hits, to the word address of the pending write, returns the pending data. Address bits [1:0] are ignored in this comparison.
- R6: A store hit writes the previously pending data to its own line. That data remains readable after the pending slot moves to another address.
- R7: Asserting flush while no store hit arrives commits any pending data to the array and empties the slot. A load issued with flush sees the pending data.
- R8: A fill writes the tag addr[31:8] and the data at line addr[7:2] and marks the line valid. A fill to the line of a pending write discards that pending write. A fill never coincides with a request or a flush.
- R9: The cache is direct-mapped. A fill to a line that already holds a different tag replaces it, and loads of the old address then miss.
- R10: A load that misses returns rsp_hit=0 and rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| flush | input | 1 | Commit and empty the pending write |
| fill_valid | input | 1 | Install a line from the next level |
| fill_addr | input | 32 | Byte address of the installed line |
| fill_data | input | 32 | Word installed into the line |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_store | output | 1 | Response belongs to a store |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_rdata | output | 32 | Load data (0 for stores and misses) |

## Verification
The checker assumes that a fill never arrives in the same cycle as a request or a flush, because both need the single array write port. It reports any such overlap. Its other properties rely on that separation, for example that a missing store leaves the pending slot untouched. The bench issues fills only from a task that holds req_valid and flush low. The mixed random phase draws addresses from a few lines with two tags each, so that bypass, replacement and commit orderings occur often.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_LINES  = 64;
endpackage

// File: rtl/dwr_tag_array.sv
module dwr_tag_array #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        vld_d = vld_q;
        if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_tag
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(g)) tag_q[g] <= wr_tag;
            end
        end
    endgenerate

    assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/dwr_data_array.sv
module dwr_data_array #(
    parameter int LINES  = 64,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] word_q [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(g)) word_q[g] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/dwr_store_pipe.sv
module dwr_store_pipe #(
    parameter int ADDR_W = dwr_pkg::DEF_ADDR_W,
    parameter int DATA_W = dwr_pkg::DEF_DATA_W,
    parameter int LINES  = dwr_pkg::DEF_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_store,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int IDX_W   = $clog2(LINES);
    localparam int OFS_W   = $clog2(DATA_W / 8);
    localparam int WADDR_W = ADDR_W - OFS_W;
    localparam int TAG_W   = ADDR_W - IDX_W - OFS_W;

    typedef struct packed {
        logic              pend_valid;
        logic [WADDR_W-1:0] pend_waddr;
        logic [DATA_W-1:0] pend_data;
        logic              rsp_valid;
        logic              rsp_store;
        logic              rsp_hit;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;

    state_t s_d, s_q;

    logic [WADDR_W-1:0] req_waddr;
    logic [IDX_W-1:0]   req_idx, fill_idx, pend_idx;
    logic [TAG_W-1:0]   req_tag, fill_tag;
    logic               tag_hit;
    logic [DATA_W-1:0]  arr_rdata;
    logic               arr_wr_en;
    logic [IDX_W-1:0]   arr_wr_idx;
    logic [DATA_W-1:0]  arr_wr_data;
    logic               store_hit, bypass_sel, commit;
    logic               pend_valid;
    logic [WADDR_W-1:0] pend_waddr;
    logic [DATA_W-1:0]  pend_data;

    assign req_waddr = req_addr[ADDR_W-1:OFS_W];
    assign req_idx   = req_addr[OFS_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign fill_idx  = fill_addr[OFS_W +: IDX_W];
    assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign pend_idx  = s_q.pend_waddr[IDX_W-1:0];

    assign pend_valid = s_q.pend_valid;
    assign pend_waddr = s_q.pend_waddr;
    assign pend_data  = s_q.pend_data;

    dwr_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_tag (req_tag),
        .rd_hit (tag_hit),
        .wr_en  (fill_valid),
        .wr_idx (fill_idx),
        .wr_tag (fill_tag)
    );

    dwr_data_array #(.LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_data (arr_rdata),
        .wr_en   (arr_wr_en),
        .wr_idx  (arr_wr_idx),
        .wr_data (arr_wr_data)
    );

    always_comb begin
        s_d        = s_q;
        store_hit  = req_valid && req_store && tag_hit;
        bypass_sel = s_q.pend_valid && (s_q.pend_waddr == req_waddr);
        commit     = s_q.pend_valid && (store_hit || flush);

        // single write port: a fill owns it, otherwise the parked store
        arr_wr_en   = fill_valid || commit;
        arr_wr_idx  = fill_valid ? fill_idx  : pend_idx;
        arr_wr_data = fill_valid ? fill_data : s_q.pend_data;

        s_d.rsp_valid = req_valid;
        s_d.rsp_store = req_valid && req_store;
        s_d.rsp_hit   = req_valid && tag_hit;
        s_d.rsp_rdata = '0;
        if (req_valid && !req_store && tag_hit)
            s_d.rsp_rdata = bypass_sel ? s_q.pend_data : arr_rdata;

        if (store_hit) begin
            s_d.pend_valid = 1'b1;
            s_d.pend_waddr = req_waddr;
            s_d.pend_data  = req_wdata;
        end else if (flush) begin
            s_d.pend_valid = 1'b0;
        end

        if (fill_valid && s_q.pend_valid && (pend_idx == fill_idx))
            s_d.pend_valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_store = s_q.rsp_store;
    assign rsp_hit   = s_q.rsp_hit;
    assign rsp_rdata = s_q.rsp_rdata;
endmodule

// File: rtl/dwr_store_pipe_chk.sv
module dwr_store_pipe_chk #(
    parameter int DATA_W  = 32,
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_store,
    input logic [WADDR_W-1:0] req_waddr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               flush,
    input logic               fill_valid,
    input logic               tag_hit,
    input logic               pend_valid,
    input logic [WADDR_W-1:0] pend_waddr,
    input logic [DATA_W-1:0]  pend_data,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [DATA_W-1:0]  rsp_rdata
);
    // R8: input rule, fill shares the write port with nothing
    a_r8_fill_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !req_valid && !flush);

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_store_hit_parks: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store && tag_hit |=>
            pend_valid && pend_data == $past(req_wdata) && pend_waddr == $past(req_waddr));

    a_r4_miss_holds_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store && !tag_hit && !flush |=>
            $stable(pend_valid) && $stable(pend_waddr) && $stable(pend_data));

    a_r5_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_store && tag_hit && pend_valid && pend_waddr == req_waddr |=>
            rsp_hit && rsp_rdata == $past(pend_data));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !(req_valid && req_store && tag_hit) |=> !pend_valid);

    a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !tag_hit |=> !rsp_hit && rsp_rdata == '0);
endmodule

bind dwr_store_pipe dwr_store_pipe_chk #(.DATA_W(DATA_W), .WADDR_W(WADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_waddr  (req_waddr),
    .req_wdata  (req_wdata),
    .flush      (flush),
    .fill_valid (fill_valid),
    .tag_hit    (tag_hit),
    .pend_valid (pend_valid),
    .pend_waddr (pend_waddr),
    .pend_data  (pend_data),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/dwr_store_pipe_tb.sv
module dwr_store_pipe_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, flush = 1'b0, fill_valid = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0, fill_addr = '0, fill_data = '0;
    logic        rsp_valid, rsp_store, rsp_hit;
    logic [31:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    bit          m_v [64];
    logic [23:0] m_t [64];
    logic [31:0] m_d [64];
    bit          p_v = 1'b0;
    logic [31:0] p_a = '0;
    logic [31:0] p_d = '0;

    always #2.5 clk = ~clk;

    dwr_store_pipe u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata),
        .flush(flush), .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_store(rsp_store), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    task automatic compare(input bit ev, es, eh, input logic [31:0] ed, input string req);
        n_cmp++;
        if (rsp_valid !== ev || rsp_store !== es || rsp_hit !== eh || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: got v=%0b s=%0b h=%0b d=%h, expected v=%0b s=%0b h=%0b d=%h",
                     req, rsp_valid, rsp_store, rsp_hit, rsp_rdata, ev, es, eh, ed);
        end
    endtask

    // one request (or idle) cycle with optional flush, checked in the next cycle
    task automatic op(input bit v, input bit st, input logic [31:0] a, input logic [31:0] d,
                      input bit fl, input string req);
        int  idx;
        bit  hit;
        logic [31:0] ed;
        @(negedge clk);
        req_valid = v; req_store = st; req_addr = a; req_wdata = d;
        flush = fl; fill_valid = 1'b0;
        idx = int'(a[7:2]);
        hit = v && m_v[idx] && (m_t[idx] == a[31:8]);
        ed  = '0;
        if (v && !st && hit)
            ed = (p_v && p_a[31:2] == a[31:2]) ? p_d : m_d[idx];
        if (v && st && hit) begin
            if (p_v) m_d[int'(p_a[7:2])] = p_d;
            p_v = 1'b1; p_a = a; p_d = d;
        end else if (fl) begin
            if (p_v) m_d[int'(p_a[7:2])] = p_d;
            p_v = 1'b0;
        end
        @(posedge clk);
        #1;
        compare(v, v && st, hit, ed, req);
    endtask

    task automatic fill(input logic [31:0] a, input logic [31:0] d);
        int idx;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        idx = int'(a[7:2]);
        m_v[idx] = 1'b1; m_t[idx] = a[31:8]; m_d[idx] = d;
        if (p_v && int'(p_a[7:2]) == idx) p_v = 1'b0;
        @(posedge clk);
        #1;
        compare(1'b0, 1'b0, 1'b0, 32'h0, "R8 fill no response");
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare(1'b0, 1'b0, 1'b0, 32'h0, "R1 reset outputs");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: everything misses after reset
        op(1, 0, 32'h0000_0010, 0, 0, "R1 R10 load after reset");
        op(1, 1, 32'h0000_0010, 32'h1111_1111, 0, "R1 store after reset");
        op(0, 0, 0, 0, 0, "R2 idle cycle");

        // R8: install lines
        fill(32'hABCD_0004, 32'hA000_0001);
        fill(32'hABCD_0008, 32'hA000_0002);
        fill(32'h1234_5608, 32'hB000_0002); // R9: same line, new tag
        fill(32'h5555_00FC, 32'hC000_003F);
        op(1, 0, 32'hABCD_0004, 0, 0, "R8 load installed line");
        op(1, 0, 32'hABCD_0008, 0, 0, "R9 replaced tag misses");
        op(1, 0, 32'h1234_5608, 0, 0, "R9 new tag hits");

        // R3 / R5: store hit then bypass with other byte offset
        op(1, 1, 32'hABCD_0004, 32'hDEAD_BEEF, 0, "R3 store hit");
        op(1, 0, 32'hABCD_0007, 0, 0, "R5 bypass low bits ignored");
        // R4: store miss keeps pending
        op(1, 1, 32'hFFFF_0004, 32'h0BAD_0BAD, 0, "R4 store miss");
        op(1, 0, 32'hABCD_0004, 0, 0, "R4 pending kept after miss");
        // R6: next store hit commits
        op(1, 1, 32'h5555_00FC, 32'h2222_3333, 0, "R6 second store hit");
        op(1, 0, 32'hABCD_0004, 0, 0, "R6 committed data in array");
        op(1, 0, 32'h5555_00FC, 0, 0, "R5 bypass new pending");
        // R7: flush with load, then after flush
        op(1, 0, 32'h5555_00FC, 0, 1, "R7 load with flush");
        op(0, 0, 0, 0, 1, "R7 flush empty slot");
        op(1, 0, 32'h5555_00FC, 0, 0, "R7 flushed data from array");
        // R8: fill to line of pending write drops it
        op(1, 1, 32'h1234_5608, 32'h7777_8888, 0, "R3 store hit before fill");
        fill(32'h1234_5608, 32'h9999_0000);
        op(1, 0, 32'h1234_5608, 0, 0, "R8 fill discards pending");
        op(1, 1, 32'h5555_00FC, 32'h4444_4444, 0, "R8 later store hit");
        op(1, 0, 32'h1234_5608, 0, 0, "R8 discarded data not committed");
        // back-to-back stores to same word
        op(1, 1, 32'hABCD_0004, 32'h0000_0001, 0, "R6 store");
        op(1, 1, 32'hABCD_0004, 32'h0000_0002, 0, "R6 store same word");
        op(1, 0, 32'hABCD_0004, 0, 0, "R5 newest store wins");

        // mixed phase over a few lines with two tags each
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {(lfsr[3] ? 24'hABCD00 : 24'h123456), 4'b0, lfsr[5:4], lfsr[7:6]};
            case (lfsr[10:8])
                3'd0:    fill(a, lfsr ^ 32'h5A5A_5A5A);
                3'd1:    op(1, 0, a, 0, 1, "R7 mixed load with flush");
                3'd2, 3'd3: op(1, 1, a, lfsr, 0, "R3 R6 mixed store");
                3'd4:    op(0, 0, 0, 0, lfsr[11], "R2 mixed idle");
                default: op(1, 0, a, 0, 0, "R5 R10 mixed load");
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule